// File: doc/BRIEF.md
# Stipple and Blit Fill Engine

This block accelerates simple 2D drawing into an 8-bit-per-pixel frame buffer with one linear pixel address space. A bus master issues single-beat commands on a valid/ready port. The destination pixel address is carried in the command's bus address. The command's 32-bit data word selects one of three operations:

- a masked stipple that paints up to 32 pixels in the foreground color;
- a run fill with that color;
- a run copy from a source pixel address.

The engine then works through the run on a single-port frame-buffer memory port, one pixel access per cycle.

The foreground color is loaded from the upper word of a 64-bit write and is kept for later 32-bit writes. When a run ends, the engine emits a one-cycle dirty pulse carrying the run's start pixel and its length, so a display controller can refresh just those pixels. Reads of either command window complete at once, return zero and change nothing.

Top module: `stipfill_engine`

## Requirements
- R1: The destination pixel is bus address bits [PIX_AW+2:3], which is (addr >> 3) masked to 20 bits by default. Higher address bits are ignored. Pixel addresses wrap modulo 2^PIX_AW.
- R2: A write to the stipple window (cmd_win=0) covers 32 pixels. Data bit 31-k controls pixel dest+k, and only pixels whose bit is 1 are written with the color.
- R3: A write to the blit window (cmd_win=1) takes its source pixel address from data bits [23:0] and its run length minus one from bits [28:24]. Runs are therefore 1 to 32 pixels long.
- R4: A blit source field equal to 24'hFFFFFF fills the run with the color instead of copying.
- R5: A read (cmd_write=0) of either window produces rsp_valid one cycle after acceptance, with rsp_data equal to zero. It makes no frame-buffer access and does not change the color.
- R6: Pixels outside the addressed run are never written.
- R7: A copy visits pixels in ascending order. For each pixel it makes one read cycle (fb_we=0) and then one write cycle, where fb_rdata is valid in the cycle after the read. An overlapping forward copy therefore replicates the pixels it has already written.
- R8: The color resets to 0. A write with cmd_wide=1 loads cmd_hi[7:0] as the color and uses it for that same command. A write with cmd_wide=0 reuses the last loaded color.
- R9: busy is high from the cycle after a write is accepted until the run ends, and cmd_ready is low while busy. A stipple run takes 32 cycles, a fill takes L cycles and a copy takes 2L cycles. A held command is accepted in the first idle cycle.
- R10: In the first cycle after a run ends, dirty_valid pulses for one cycle. It carries dirty_addr set to the destination start and dirty_len set to the run length, which is 32 for a stipple.
- R11: After reset the engine is idle: cmd_ready=1, busy=0, fb_req=0, dirty_valid=0 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_win | input | 1 | 0 = stipple window, 1 = blit window |
| cmd_wide | input | 1 | 64-bit write; cmd_hi carries the color |
| cmd_addr | input | BUS_AW | Byte offset within the window |
| cmd_data | input | 32 | Mask, or length/source word |
| cmd_hi | input | 32 | Upper data word of a 64-bit write |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Read response data (zero) |
| busy | output | 1 | Run in progress |
| fb_req | output | 1 | Frame-buffer access this cycle |
| fb_we | output | 1 | Access is a write |
| fb_addr | output | PIX_AW | Pixel address |
| fb_wdata | output | 8 | Pixel write data |
| fb_rdata | input | 8 | Pixel read data, valid one cycle after a read |
| dirty_valid | output | 1 | Run-complete pulse |
| dirty_addr | output | PIX_AW | First pixel of the finished run |
| dirty_len | output | 6 | Pixels in the finished run |

## Verification
The bench goes after the following corner cases:

- **Bit order of the stipple mask.** An engine that scans the mask from the LSB would paint the mirrored pixel set.
- **Single-pixel and full 32-pixel blits.** An off-by-one in the length field would write one pixel too many or too few, and the neighbouring-pixel checks would catch it.
- **Forward-overlapping copy.** An engine that read ahead, or copied in descending order, would shift the data instead of replicating the first pixel.
- **A wide write followed by narrow writes.** This shows whether the color is taken for the loading command itself and held afterwards.
- **A command queued behind a busy run.** It must wait exactly until the run drains and must not be lost.
- **A run that crosses the top of the pixel space.** It must wrap to pixel zero.

// File: rtl/stipfill_pkg.sv
package stipfill_pkg;
  localparam int SRC_W    = 24;
  localparam int RUN_MAX  = 32;
  localparam int LEN_LSB  = 24;

  typedef enum logic [1:0] {OP_STIP, OP_FILL, OP_COPY} op_kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_STIP, ST_FILL, ST_CRD, ST_CWR} seq_state_e;

  // Blit run length minus one, taken from the data word.
  function automatic logic [4:0] blit_len_m1(input logic [31:0] w);
    return w[LEN_LSB+4:LEN_LSB];
  endfunction

  // All-ones source means solid fill.
  function automatic logic blit_is_fill(input logic [31:0] w);
    return w[SRC_W-1:0] == {SRC_W{1'b1}};
  endfunction

  function automatic logic [5:0] run_len(input logic [4:0] len_m1);
    return {1'b0, len_m1} + 6'd1;
  endfunction
endpackage

// File: rtl/stipfill_decode.sv
module stipfill_decode
  import stipfill_pkg::*;
#(
  parameter int BUS_AW = 24,
  parameter int PIX_AW = 20
) (
  input  logic              cmd_valid,
  input  logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_win,
  input  logic [BUS_AW-1:0] cmd_addr,
  input  logic [31:0]       cmd_data,
  output logic              start,
  output logic              rd_accept,
  output op_kind_e          op,
  output logic [PIX_AW-1:0] dst,
  output logic [PIX_AW-1:0] src,
  output logic [4:0]        len_m1,
  output logic [31:0]       mask
);
  assign start     = cmd_valid & cmd_ready & cmd_write;
  assign rd_accept = cmd_valid & cmd_ready & ~cmd_write;
  // Destination pixel: bus address shifted down by three, PIX_AW bits kept.
  assign dst       = cmd_addr[PIX_AW+2:3];
  assign src       = cmd_data[PIX_AW-1:0];
  assign mask      = cmd_data;

  always_comb begin
    if (!cmd_win)                    op = OP_STIP;
    else if (blit_is_fill(cmd_data)) op = OP_FILL;
    else                             op = OP_COPY;
  end

  assign len_m1 = (op == OP_STIP) ? 5'(RUN_MAX - 1) : blit_len_m1(cmd_data);
endmodule

// File: rtl/stipfill_color.sv
module stipfill_color (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] new_color,
  output logic [7:0] op_color
);
  logic [7:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= new_color;
  end

  // A loading command paints with its own color.
  assign op_color = load ? new_color : held;
endmodule

// File: rtl/stipfill_seq.sv
module stipfill_seq
  import stipfill_pkg::*;
#(
  parameter int PIX_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_kind_e          op,
  input  logic [PIX_AW-1:0] dst,
  input  logic [PIX_AW-1:0] src,
  input  logic [4:0]        len_m1,
  input  logic [31:0]       mask,
  input  logic [7:0]        color,
  output logic              busy,
  output logic              fb_req,
  output logic              fb_we,
  output logic [PIX_AW-1:0] fb_addr,
  output logic [7:0]        fb_wdata,
  input  logic [7:0]        fb_rdata,
  output logic              dirty_valid,
  output logic [PIX_AW-1:0] dirty_addr,
  output logic [5:0]        dirty_len
);
  seq_state_e        state;
  logic [PIX_AW-1:0] r_dst, r_src;
  logic [4:0]        r_len_m1, idx;
  logic [31:0]       r_mask;
  logic [7:0]        r_color;
  logic              last, run_done;
  logic [PIX_AW-1:0] cur_dst, cur_src;

  assign last     = (idx == r_len_m1);
  assign cur_dst  = r_dst + PIX_AW'(idx);
  assign cur_src  = r_src + PIX_AW'(idx);
  assign busy     = (state != ST_IDLE);
  assign run_done = last && (state == ST_STIP || state == ST_FILL || state == ST_CWR);

  always_comb begin
    fb_req   = 1'b0;
    fb_we    = 1'b0;
    fb_addr  = cur_dst;
    fb_wdata = r_color;
    unique case (state)
      ST_STIP: begin fb_req = r_mask[5'd31 - idx]; fb_we = 1'b1; end
      ST_FILL: begin fb_req = 1'b1; fb_we = 1'b1; end
      ST_CRD:  begin fb_req = 1'b1; fb_addr = cur_src; end
      ST_CWR:  begin fb_req = 1'b1; fb_we = 1'b1; fb_wdata = fb_rdata; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      idx         <= '0;
      r_dst       <= '0;
      r_src       <= '0;
      r_len_m1    <= '0;
      r_mask      <= '0;
      r_color     <= '0;
      dirty_valid <= 1'b0;
    end else begin
      dirty_valid <= run_done;
      unique case (state)
        ST_IDLE: if (start) begin
          r_dst    <= dst;
          r_src    <= src;
          r_len_m1 <= len_m1;
          r_mask   <= mask;
          r_color  <= color;
          idx      <= '0;
          unique case (op)
            OP_STIP: state <= ST_STIP;
            OP_FILL: state <= ST_FILL;
            default: state <= ST_CRD;
          endcase
        end
        ST_STIP, ST_FILL: begin
          if (last) state <= ST_IDLE;
          else      idx   <= idx + 5'd1;
        end
        ST_CRD: state <= ST_CWR;
        ST_CWR: begin
          if (last) state <= ST_IDLE;
          else begin
            idx   <= idx + 5'd1;
            state <= ST_CRD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dirty_addr = r_dst;
  assign dirty_len  = run_len(r_len_m1);

  // R7: every copy read is followed by the matching write.
  assert_copy_rd_then_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_req && !fb_we) |=> (fb_req && fb_we));

  // R3: fill addresses climb by one pixel per cycle.
  assert_fill_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL && $past(state == ST_FILL)) |-> fb_addr == $past(fb_addr) + PIX_AW'(1));

  // R10: the dirty pulse marks the end of a run.
  assert_dirty_after_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |-> ($past(busy) && !busy));
endmodule

// File: rtl/stipfill_engine.sv
module stipfill_engine
  import stipfill_pkg::*;
#(
  parameter int BUS_AW = 24,
  parameter int PIX_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_win,
  input  logic              cmd_wide,
  input  logic [BUS_AW-1:0] cmd_addr,
  input  logic [31:0]       cmd_data,
  input  logic [31:0]       cmd_hi,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              busy,
  output logic              fb_req,
  output logic              fb_we,
  output logic [PIX_AW-1:0] fb_addr,
  output logic [7:0]        fb_wdata,
  input  logic [7:0]        fb_rdata,
  output logic              dirty_valid,
  output logic [PIX_AW-1:0] dirty_addr,
  output logic [5:0]        dirty_len
);
  logic              start, rd_accept;
  op_kind_e          op;
  logic [PIX_AW-1:0] dst, src;
  logic [4:0]        len_m1;
  logic [31:0]       mask;
  logic [7:0]        op_color;

  assign cmd_ready = ~busy;
  assign rsp_data  = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rd_accept;
  end

  stipfill_decode #(.BUS_AW(BUS_AW), .PIX_AW(PIX_AW)) u_dec (
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_win(cmd_win), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .start(start), .rd_accept(rd_accept), .op(op), .dst(dst), .src(src),
    .len_m1(len_m1), .mask(mask)
  );

  stipfill_color u_color (
    .clk(clk), .rst_n(rst_n), .load(start & cmd_wide),
    .new_color(cmd_hi[7:0]), .op_color(op_color)
  );

  stipfill_seq #(.PIX_AW(PIX_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dst(dst), .src(src),
    .len_m1(len_m1), .mask(mask), .color(op_color), .busy(busy),
    .fb_req(fb_req), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .fb_rdata(fb_rdata), .dirty_valid(dirty_valid), .dirty_addr(dirty_addr),
    .dirty_len(dirty_len)
  );

  // R5: an accepted read starts no frame-buffer traffic.
  assert_read_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> !fb_req);

  // R9: an accepted write makes the engine busy on the next cycle.
  assert_write_goes_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: tb/stipfill_engine_test.sv
module stipfill_engine_test;
  localparam int BUS_AW = 24;
  localparam int PIX_AW = 20;
  localparam int PMASK  = (1 << PIX_AW) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0, cmd_write = 1'b0, cmd_win = 1'b0, cmd_wide = 1'b0;
  logic [BUS_AW-1:0] cmd_addr = '0;
  logic [31:0]       cmd_data = '0, cmd_hi = '0;
  logic              cmd_ready, rsp_valid, busy, fb_req, fb_we, dirty_valid;
  logic [31:0]       rsp_data;
  logic [PIX_AW-1:0] fb_addr, dirty_addr;
  logic [7:0]        fb_wdata;
  logic [7:0]        fb_rdata = '0;
  logic [5:0]        dirty_len;

  always #4 clk = ~clk;

  stipfill_engine #(.BUS_AW(BUS_AW), .PIX_AW(PIX_AW)) uut (.*);

  int  n_cmp = 0, n_bad = 0;
  bit  done_flag = 1'b0;
  byte mem [int];
  byte refm [int];
  byte ref_color = 8'h00;

  function automatic byte pat(int a);
    return byte'((a * 37 + 11) & 8'hFF);
  endfunction
  function automatic byte mem_rd(int a);
    return mem.exists(a) ? mem[a] : pat(a);
  endfunction
  function automatic byte ref_rd(int a);
    return refm.exists(a) ? refm[a] : pat(a);
  endfunction

  // Frame-buffer memory: one-cycle read latency.
  always @(posedge clk) begin
    if (fb_req) begin
      if (fb_we) mem[int'(fb_addr)] = fb_wdata;
      else       fb_rdata <= mem_rd(int'(fb_addr));
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_region(input string req, input int lo, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      int a = (lo + k) & PMASK;
      check(req, mem_rd(a), ref_rd(a));
    end
  endtask

  // Reference operations.
  task automatic ref_stip(input int d, input logic [31:0] m);
    for (int k = 0; k < 32; k++)
      if (m[31-k]) refm[(d + k) & PMASK] = ref_color;
  endtask
  task automatic ref_blit(input int d, input int s, input int len, input bit fill);
    for (int k = 0; k < len; k++) begin
      if (fill) refm[(d + k) & PMASK] = ref_color;
      else      refm[(d + k) & PMASK] = ref_rd((s + k) & PMASK);
    end
  endtask

  // Drive one command at a negedge; return at the negedge after acceptance.
  task automatic issue(input bit wr, input bit win, input bit wide, input logic [23:0] addr,
                       input logic [31:0] data, input logic [31:0] hi, output int stalls);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_win = win; cmd_wide = wide;
    cmd_addr = addr; cmd_data = data; cmd_hi = hi;
    stalls = 0;
    while (!cmd_ready) begin stalls++; @(negedge clk); end
    @(negedge clk);
    cmd_valid = 1'b0; cmd_wide = 1'b0;
  endtask

  // Busy for n cycles, then the dirty pulse.
  task automatic run_check(input string req, input int n, input int d, input int len);
    for (int i = 0; i < n; i++) begin
      check({req, " busy"}, busy, 1);
      @(negedge clk);
    end
    check("R9 idle", busy, 0);
    check("R10 dirty_valid", dirty_valid, 1);
    check("R10 dirty_addr", dirty_addr, d);
    check("R10 dirty_len", dirty_len, len);
  endtask

  function automatic logic [31:0] blit_word(int len, int s);
    return {3'b000, 5'(len - 1), 24'(s)};
  endfunction

  task automatic do_stip(input int d, input logic [31:0] m, input bit wide, input byte col);
    int st;
    if (wide) ref_color = col;
    ref_stip(d, m);
    issue(1, 0, wide, 24'(d << 3), m, {24'h0, col}, st);
    run_check("R2", 32, d, 32);
    cmp_region("R2/R6", d - 2, 36);
  endtask

  task automatic do_blit(input int d, input int s, input int len, input bit wide, input byte col);
    int st;
    bit fill = (s == 24'hFFFFFF);
    if (wide) ref_color = col;
    ref_blit(d, s, len, fill);
    issue(1, 1, wide, 24'(d << 3), blit_word(len, s), {24'h0, col}, st);
    run_check(fill ? "R4" : "R7", fill ? len : 2 * len, d & PMASK, len);
    cmp_region("R3/R6", d - 2, len + 4);
  endtask

  initial begin
    int st;
    repeat (3) @(negedge clk);
    // R11: reset state.
    check("R11 ready", cmd_ready, 1);
    check("R11 busy", busy, 0);
    check("R11 fb_req", fb_req, 0);
    check("R11 dirty", dirty_valid, 0);
    check("R11 rsp", rsp_valid, 0);
    rst_n = 1'b1;

    // R1, R2, R8: wide stipple, corner mask bits.
    do_stip(100, 32'h8000_0001, 1, 8'h5A);
    // R2, R8: narrow stipple reuses the color.
    do_stip(300, 32'hF0F0_0F0F, 0, 8'h00);
    // R4, R3: full 32-pixel fill with new color.
    do_blit(1000, 24'hFFFFFF, 32, 1, 8'hC3);
    // R3: single-pixel fill.
    do_blit(1100, 24'hFFFFFF, 1, 0, 8'h00);
    // R7: plain copy.
    do_blit(2000, 1000, 5, 0, 8'h00);
    // R7: overlapping forward copy replicates the first pixel.
    do_blit(3001, 3000, 8, 0, 8'h00);
    // R8: a wide copy loads the color but copies data.
    do_blit(4000, 100, 3, 1, 8'h77);
    do_stip(4100, 32'h0000_0003, 0, 8'h00);

    // R5: reads of both windows.
    for (int w = 0; w < 2; w++) begin
      issue(0, w[0], 1, 24'(5000 << 3), 32'hFFFF_FFFF, 32'h0000_00EE, st);
      check("R5 rsp_valid", rsp_valid, 1);
      check("R5 rsp_data", rsp_data, 0);
      check("R5 fb_req", fb_req, 0);
      check("R5 busy", busy, 0);
      @(negedge clk);
      check("R5 fb_req2", fb_req, 0);
    end
    cmp_region("R5 mem", 4998, 36);
    // R5/R8: the color after the reads is still 8'h77.
    do_stip(4200, 32'h4000_0000, 0, 8'h00);

    // R1: address bit 23 is ignored; wrap over the top of pixel space.
    begin
      int d = PMASK - 1;
      ref_color = 8'h3C;
      ref_blit(d, 24'hFFFFFF, 4, 1);
      issue(1, 1, 1, 24'h800000 | 24'(d << 3), blit_word(4, 24'hFFFFFF), 32'h3C, st);
      run_check("R1", 4, d, 4);
      cmp_region("R1 wrap", d - 2, 8);
    end

    // R9: second command is held until the stipple run drains.
    ref_stip(6000, 32'hAAAA_5555);
    issue(1, 0, 0, 24'(6000 << 3), 32'hAAAA_5555, 32'h0, st);
    ref_blit(6100, 24'hFFFFFF, 6, 1);
    issue(1, 1, 0, 24'(6100 << 3), blit_word(6, 24'hFFFFFF), 32'h0, st);
    check("R9 stall cycles", st, 31);
    run_check("R9", 6, 6100, 6);
    cmp_region("R9 first", 5998, 36);
    cmp_region("R9 second", 6098, 10);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule